// File: doc/BRIEF.md
# Block-Granular Secure Access Filter

This block sits on the path from an upstream memory bus to a downstream memory. The memory is divided into equal, power-of-two sized blocks. Each block owns a single permission bit, held in a table of 32-bit words. The table is supplied on a flat input port by a separate configuration block. For every request the filter looks up the bit of the addressed block and compares it with the request's security attribute. A matching request is passed through to the downstream side untouched. A mismatching request is answered locally in the same cycle and never appears downstream.

When a request is refused, the filter can record what happened. If no interrupt is pending, the refused request's address and a descriptor word are captured into two hold registers, and the interrupt status is set. While the status stays set, later refusals are still answered but do not replace the captured record. Software clears the status with a pulse input. A configuration bit chooses how refused requests are answered: either with an error, or with a normal completion where a read returns zero and a write is dropped.

Top module: `blk_sec_filter`

## Requirements
- R1: The block index is `up_addr` divided by BLK_BYTES. The table word is index/32 and the bit within it is index%32. Table word w, bit j is read from `lut_map[w*32+j]`.
- R2: A bit of 1 admits only non-secure requests, and a bit of 0 admits only secure ones. The effective attribute is non-secure only when `up_nonsec`=1 and `up_attr_unknown`=0; an unknown attribute counts as secure.
- R3: An admitted request drives `dn_valid` in the same cycle with address, write flag and write data unchanged. `up_ready`, `up_rdata` and `up_err` follow `dn_ready`, `dn_rdata` and `dn_err` combinationally, including stalls.
- R4: A refused request keeps `dn_valid` low and gets `up_ready`=1 in the same cycle with `up_rdata`=0.
- R5: For a refused request, `up_err` equals `cfg_sec_resp`.
- R6: A refused request seen at a clock edge while `irq_status`=0 loads `info_addr` with the zero-extended address. It also loads `info_word` with bits 15:0 = `up_master`, bit 16 = effective non-secure attribute, bit 17 = the block's table bit and the other bits 0, and it sets `irq_status`.
- R7: While `irq_status` stays 1, refused requests do not change `info_addr` or `info_word`.
- R8: `irq` is 1 exactly when `irq_status`=1 and `cfg_irq_en`=1.
- R9: A `cfg_irq_clr` pulse clears `irq_status` unless a capture or a `cfg_irq_set` pulse occurs in the same cycle, in which case the status is set. `cfg_irq_set` sets the status without touching the info registers.
- R10: After reset `irq_status`, `info_addr` and `info_word` are 0.
- R11: `blk_size_code` is the constant log2(BLK_BYTES)-5. The table holds ceil((MEM_BYTES/BLK_BYTES)/32) words, and `lut_map` is that many words times 32 bits wide.
- R12: A change on `lut_map` takes effect for the very next request, with no stored copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_write | input | 1 | Upstream request is a write |
| up_addr | input | AW | Upstream byte address, AW = log2(MEM_BYTES) |
| up_wdata | input | DW | Upstream write data |
| up_nonsec | input | 1 | Request is non-secure |
| up_attr_unknown | input | 1 | Security attribute not specified (treated as secure) |
| up_master | input | 16 | Requesting master identifier |
| up_ready | output | 1 | Request completes this cycle |
| up_rdata | output | DW | Read data to upstream |
| up_err | output | 1 | Error response to upstream |
| dn_valid | output | 1 | Downstream request valid |
| dn_write | output | 1 | Downstream write flag |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_ready | input | 1 | Downstream completes request |
| dn_rdata | input | DW | Downstream read data |
| dn_err | input | 1 | Downstream error response |
| lut_map | input | NWORDS*32 | Block permission table |
| cfg_sec_resp | input | 1 | 1: refused requests answer with error |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_irq_clr | input | 1 | Pulse: clear interrupt status |
| cfg_irq_set | input | 1 | Pulse: set interrupt status |
| irq | output | 1 | Interrupt request |
| irq_status | output | 1 | Interrupt status (fault record held) |
| info_addr | output | 32 | Captured address of first refused request |
| info_word | output | 32 | Captured master, attribute and table bit |
| blk_size_code | output | 8 | log2(BLK_BYTES)-5 |

## Verification
A wrong table lookup or attribute decision shows up in the same cycle as the request: `dn_valid`, `up_ready` or `up_err` take the wrong value while the request is still on the bus. A wrong hold state shows up one edge after a refused request. That state is the status flag and the two capture registers. Symptoms are a missing `irq_status` rise, a record overwritten by a later refusal, or `irq` failing to follow the enable. The bench covers several blocks in different table words, including the last block. It also covers every attribute combination, status set and clear collisions, and a table change made mid-run.

// File: rtl/blk_sec_filter.sv
module blk_sec_filter #(
  parameter int MEM_BYTES = 65536,
  parameter int BLK_BYTES = 256,
  parameter int DW = 32,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int NWORDS = ((MEM_BYTES / BLK_BYTES) + 31) / 32,
  localparam int LUT_BITS = NWORDS * 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_valid,
  input  logic                up_write,
  input  logic [AW-1:0]       up_addr,
  input  logic [DW-1:0]       up_wdata,
  input  logic                up_nonsec,
  input  logic                up_attr_unknown,
  input  logic [15:0]         up_master,
  output logic                up_ready,
  output logic [DW-1:0]       up_rdata,
  output logic                up_err,
  output logic                dn_valid,
  output logic                dn_write,
  output logic [AW-1:0]       dn_addr,
  output logic [DW-1:0]       dn_wdata,
  input  logic                dn_ready,
  input  logic [DW-1:0]       dn_rdata,
  input  logic                dn_err,
  input  logic [LUT_BITS-1:0] lut_map,
  input  logic                cfg_sec_resp,
  input  logic                cfg_irq_en,
  input  logic                cfg_irq_clr,
  input  logic                cfg_irq_set,
  output logic                irq,
  output logic                irq_status,
  output logic [31:0]         info_addr,
  output logic [31:0]         info_word,
  output logic [7:0]          blk_size_code
);
  localparam int BLK_SH = $clog2(BLK_BYTES);
  localparam int IW = AW - BLK_SH;

  logic [IW-1:0] blk_idx;
  logic [4:0]    bit_pos;
  logic [31:0]   sel_word;
  logic          lut_bit, eff_ns, pass, capture;

  assign blk_idx = up_addr[AW-1:BLK_SH];
  assign bit_pos = 5'(blk_idx);

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < NWORDS; w++)
      if (w == (int'(blk_idx) >> 5)) sel_word = lut_map[w*32 +: 32];
  end

  assign lut_bit = sel_word[bit_pos];
  assign eff_ns  = up_nonsec & ~up_attr_unknown;
  assign pass    = (lut_bit == eff_ns);
  assign capture = up_valid & ~pass & ~irq_status;

  assign dn_valid = up_valid & pass;
  assign dn_write = up_write;
  assign dn_addr  = up_addr;
  assign dn_wdata = up_wdata;

  assign up_ready = pass ? dn_ready : 1'b1;
  assign up_rdata = pass ? dn_rdata : '0;
  assign up_err   = pass ? dn_err : cfg_sec_resp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_status <= 1'b0;
      info_addr  <= '0;
      info_word  <= '0;
    end else begin
      if (capture) begin
        info_addr <= 32'(up_addr);
        info_word <= {14'd0, lut_bit, eff_ns, up_master};
      end
      if (capture || cfg_irq_set) irq_status <= 1'b1;
      else if (cfg_irq_clr)       irq_status <= 1'b0;
    end
  end

  assign irq = irq_status & cfg_irq_en;
  assign blk_size_code = 8'(BLK_SH - 5);
endmodule

module blk_sec_filter_chk #(
  parameter int MEM_BYTES = 65536,
  parameter int BLK_BYTES = 256,
  parameter int DW = 32,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int NWORDS = ((MEM_BYTES / BLK_BYTES) + 31) / 32,
  localparam int LUT_BITS = NWORDS * 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                up_valid,
  input logic [AW-1:0]       up_addr,
  input logic                up_nonsec,
  input logic                up_attr_unknown,
  input logic                up_ready,
  input logic [DW-1:0]       up_rdata,
  input logic                up_err,
  input logic                dn_valid,
  input logic                dn_ready,
  input logic                dn_err,
  input logic [LUT_BITS-1:0] lut_map,
  input logic                cfg_sec_resp,
  input logic                cfg_irq_en,
  input logic                cfg_irq_clr,
  input logic                cfg_irq_set,
  input logic                irq,
  input logic                irq_status,
  input logic [31:0]         info_addr,
  input logic [31:0]         info_word
);
  logic ck_bit, ck_ns, ck_block;

  always_comb begin
    ck_bit = 1'b0;
    for (int i = 0; i < LUT_BITS; i++)
      if (i == int'(up_addr) / BLK_BYTES) ck_bit = lut_map[i];
  end
  assign ck_ns    = up_nonsec && !up_attr_unknown;
  assign ck_block = up_valid && (ck_bit != ck_ns);

  // R3
  pass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !ck_block |-> dn_valid && up_ready == dn_ready && up_err == dn_err);
  // R4
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_block |-> !dn_valid && up_ready && up_rdata == '0);
  // R5
  blocked_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_block |-> up_err == cfg_sec_resp);
  // R6
  capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_block && !irq_status |=> irq_status);
  // R7
  info_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status && $past(irq_status) |-> $stable(info_addr) && $stable(info_word));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_status && cfg_irq_en);
  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status && cfg_irq_en |-> irq);
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_irq_clr && !cfg_irq_set && !(ck_block && !irq_status) |=> !irq_status);
endmodule

bind blk_sec_filter blk_sec_filter_chk #(
  .MEM_BYTES(MEM_BYTES), .BLK_BYTES(BLK_BYTES), .DW(DW)
) u_chk (.*);

// File: tb/sim_blk_sec_filter.sv
module sim_blk_sec_filter;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LB = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_valid = 0, up_write = 0, up_nonsec = 0, up_attr_unknown = 0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic [15:0] up_master = '0;
  logic up_ready, up_err, dn_valid, dn_write;
  logic [DW-1:0] up_rdata, dn_wdata, dn_rdata;
  logic [AW-1:0] dn_addr;
  logic dn_ready = 1, dn_err = 0;
  logic [LB-1:0] lut_map = '0;
  logic cfg_sec_resp = 1, cfg_irq_en = 1, cfg_irq_clr = 0, cfg_irq_set = 0;
  logic irq, irq_status;
  logic [31:0] info_addr, info_word;
  logic [7:0] blk_size_code;
  int total = 0, bad = 0;
  bit done = 0;

  assign dn_rdata = {16'hD00D, dn_addr};

  always #5 clk = ~clk;

  blk_sec_filter u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic ns, input logic unk,
                       input logic wr, input logic [15:0] m);
    up_valid = 1; up_addr = a; up_nonsec = ns; up_attr_unknown = unk;
    up_write = wr; up_master = m; up_wdata = {m, a};
  endtask

  // addr[35:20] ns[19] unk[18] wr[17] master[16:1] pass[0]
  localparam logic [35:0] VEC [0:9] = '{
    {16'h0010, 1'b0, 1'b0, 1'b1, 16'h0A01, 1'b1},
    {16'h0024, 1'b1, 1'b0, 1'b0, 16'h0A02, 1'b0},
    {16'h0404, 1'b1, 1'b0, 1'b0, 16'h0A03, 1'b1},
    {16'h0408, 1'b0, 1'b0, 1'b1, 16'h0A04, 1'b0},
    {16'h0410, 1'b1, 1'b1, 1'b0, 16'h0A05, 1'b0},
    {16'h7F20, 1'b1, 1'b0, 1'b0, 16'h0A06, 1'b1},
    {16'h7E08, 1'b0, 1'b0, 1'b0, 16'h0A07, 1'b1},
    {16'hFF80, 1'b1, 1'b0, 1'b1, 16'h0A08, 1'b0},
    {16'hFFFC, 1'b0, 1'b0, 1'b0, 16'h0A09, 1'b1},
    {16'h0500, 1'b0, 1'b0, 1'b0, 16'h0A0A, 1'b0}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    lut_map[31:0]   = 32'hF0F0_F0F0;
    lut_map[127:96] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 status", 32'(irq_status), 0);
    chk("R10 info_addr", info_addr, 0);
    chk("R10 info_word", info_word, 0);
    chk("R8 irq after reset", 32'(irq), 0);
    // R11
    chk("R11 size code", 32'(blk_size_code), 3);
    rst_n = 1;

    // R1 R2 R3 R4 R5: table walk, error response selected
    for (int i = 0; i < 10; i++) begin
      logic [35:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[35:20], v[19], v[18], v[17], v[16:1]);
      #2;
      chk("R2 dn_valid", 32'(dn_valid), 32'(v[0]));
      chk("R4 up_ready", 32'(up_ready), 1);
      chk("R5 up_err", 32'(up_err), 32'(!v[0]));
      if (v[0]) begin
        chk("R3 dn_addr", 32'(dn_addr), 32'(v[35:20]));
        chk("R3 dn_wdata", dn_wdata, {v[16:1], v[35:20]});
        if (!v[17]) chk("R3 rdata", up_rdata, {16'hD00D, v[35:20]});
      end else chk("R4 rdata zero", up_rdata, 0);
      @(negedge clk);
      up_valid = 0;
    end

    // R6 R7: first fault record held
    chk("R6 status set", 32'(irq_status), 1);
    chk("R7 info_addr first", info_addr, 32'h0024);
    chk("R7 info_word first", info_word, 32'h0001_0A02);
    chk("R8 irq on", 32'(irq), 1);
    cfg_irq_en = 0; #1;
    chk("R8 irq masked", 32'(irq), 0);
    cfg_irq_en = 1; #1;
    chk("R8 irq unmasked", 32'(irq), 1);

    // R4 R5: silent response
    cfg_sec_resp = 0;
    @(negedge clk); drive(16'h0024, 1, 0, 1, 16'h1234); #2;
    chk("R5 no err", 32'(up_err), 0);
    chk("R4 write dropped", 32'(dn_valid), 0);
    chk("R4 ready", 32'(up_ready), 1);
    @(negedge clk); drive(16'h0024, 1, 0, 0, 16'h1234); #2;
    chk("R4 read zero", up_rdata, 0);
    @(negedge clk); up_valid = 0;
    chk("R7 still held", info_word, 32'h0001_0A02);

    // R9 clear
    cfg_irq_clr = 1; @(negedge clk); cfg_irq_clr = 0;
    chk("R9 cleared", 32'(irq_status), 0);
    chk("R8 irq off", 32'(irq), 0);

    // R6 new capture, table bit 1
    drive(16'h0408, 0, 0, 0, 16'hBEEF); @(negedge clk); up_valid = 0;
    chk("R6 addr", info_addr, 32'h0408);
    chk("R6 word", info_word, 32'h0002_BEEF);

    // R9 clear and capture in the same cycle: set wins
    cfg_irq_clr = 1; @(negedge clk);
    chk("R9 clear again", 32'(irq_status), 0);
    drive(16'hFF80, 1, 0, 1, 16'h0055); @(negedge clk);
    up_valid = 0; cfg_irq_clr = 0;
    chk("R9 capture wins", 32'(irq_status), 1);
    chk("R6 addr last block", info_addr, 32'hFF80);
    chk("R6 word last block", info_word, 32'h0001_0055);

    // R9 set pulse without capture
    cfg_irq_clr = 1; @(negedge clk); cfg_irq_clr = 0;
    cfg_irq_set = 1; @(negedge clk); cfg_irq_set = 0;
    chk("R9 set pulse", 32'(irq_status), 1);
    chk("R9 set keeps info", info_addr, 32'hFF80);

    // R12 live table change
    lut_map[0] = 1'b1;
    drive(16'h0010, 1, 0, 0, 16'h0001); #2;
    chk("R12 ns now passes", 32'(dn_valid), 1);
    @(negedge clk); drive(16'h0010, 0, 0, 0, 16'h0001); #2;
    chk("R12 sec now refused", 32'(dn_valid), 0);
    @(negedge clk); up_valid = 0;

    // R3 stall and error forwarded
    dn_ready = 0; dn_err = 1;
    drive(16'hFFFC, 0, 0, 0, 16'h0002); #2;
    chk("R3 stall", 32'(up_ready), 0);
    chk("R3 err fwd", 32'(up_err), 1);
    @(negedge clk); dn_ready = 1; #2;
    chk("R3 release", 32'(up_ready), 1);
    @(negedge clk); up_valid = 0; dn_err = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule